// File: doc/BRIEF.md
# Command-Stream SPI Host Register Frontend

This block is the host-facing register and interrupt layer of an SPI controller that runs a stream of 16-bit commands. A host drives a simple memory-mapped read/write port with 32-bit data and byte offsets that step by four. Through this port it loads commands and outgoing bytes into two FIFOs and drains received bytes from a third. It can also observe the free room and fill level of each FIFO, read a captured synchronisation ID and a version word, and hold the engine and all FIFOs in a soft reset.

On the engine side the block offers three valid/ready byte or word streams (commands out, transmit bytes out, receive bytes in) and a sync-event input that carries an 8-bit ID. One interrupt line combines four sticky sources: command FIFO low, transmit FIFO low, receive FIFO high and sync event. The three FIFO sources are watermark comparisons against fixed parameters and are evaluated again on every cycle.

Host reads are registered. The read data and `rdValid` appear in the cycle after the cycle in which `rdEn` is sampled. Writes take effect at the clock edge that samples `wrEn`.

Top module: `cmdspi_host_regs`

## Requirements
- R1: Offset 0x00 reads the version word: major number in bits [23:16] (equal to 1), minor in [15:8], patch in [7:0], and zero in bits [31:24]. With the default parameters it reads 0x00010061.
- R2: The soft-reset bit at offset 0x40 (bit 0) is 1 after `rstN` and reads back. While it is 1, `engineRst` is high, all FIFOs are empty, host pushes and engine input bytes are ignored, `cmdValid`, `outValid` and `inReady` are low, and enable, pending and sync-ID registers keep their values. Writing 0 releases the engine and the FIFOs.
- R3: Offset 0xD0 reads the free command-FIFO entries, 0xD4 the free transmit-FIFO entries and 0xD8 the receive-FIFO fill level.
- R4: A write to 0xE0 pushes `wrData[15:0]` into the command FIFO. Commands leave on `cmdData` in push order, one per cycle in which `cmdValid` and `cmdReady` are both high.
- R5: A write to 0xE4 pushes `wrData[7:0]` into the transmit FIFO. Bytes leave on `outData` in push order under `outValid`/`outReady`.
- R6: A byte on `inData` is stored when `inValid` and `inReady` are both high. `inReady` is high only while the receive FIFO is below full and the soft reset is released. A read of 0xE8 returns the oldest byte in bits [7:0] and removes it.
- R7: A read of 0xEC returns the oldest received byte and leaves the receive FIFO unchanged.
- R8: A push into a full FIFO is dropped and leaves the contents unchanged. A read of 0xE8 on an empty receive FIFO returns 0 and leaves the level at 0.
- R9: Pending register 0x84 holds bit 0 when the command level is at most CMD_LOW_MARK, bit 1 when the transmit level is at most OUT_LOW_MARK, bit 2 when the receive level is at least IN_HIGH_MARK, and bit 3 after a sync event. A watermark bit is set at the edge after the level meets its condition.
- R10: Writing 1 to a pending bit clears it and writing 0 leaves it. A watermark bit whose condition still holds is set again at the same edge, so it reads back as 1.
- R11: When `syncValid` is high at an edge, `syncId` is stored in the register at offset 0xC0 (bits [7:0]) and pending bit 3 is set.
- R12: Offset 0x88 reads pending AND enable. `irq` is high exactly when that value is non-zero.
- R13: The enable register at 0x80 holds `wrData[3:0]`, reads back with zeros above bit 3, and is 0 after `rstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte offset |
| wrData | input | 32 | Host write data |
| rdData | output | 32 | Registered host read data |
| rdValid | output | 1 | High in the cycle after an accepted read |
| irq | output | 1 | Interrupt line |
| engineRst | output | 1 | Soft reset towards the engine |
| cmdValid | output | 1 | Command available |
| cmdReady | input | 1 | Engine takes the command |
| cmdData | output | 16 | Command word |
| outValid | output | 1 | Transmit byte available |
| outReady | input | 1 | Engine takes the transmit byte |
| outData | output | 8 | Transmit byte |
| inValid | input | 1 | Engine offers a received byte |
| inReady | output | 1 | Receive FIFO accepts a byte |
| inData | input | 8 | Received byte |
| syncValid | input | 1 | Sync event strobe |
| syncId | input | 8 | Sync event ID |

## Verification
Directed sequences fill each FIFO past its depth, read the receive FIFO when it is empty, and peek twice before popping. Each of these marks an edge case that a plain push/pop stream never reaches. Sync pulses are interleaved with pending clears and enable masks, which shows whether sticky sync bits behave differently from watermark bits that set again. A long seeded random mix of host pushes, engine pulls, receive bytes, peeks and pops follows. It compares every level, every returned byte and the freshly cleared pending word against queue models. This exposes ordering, level-arithmetic and threshold-boundary errors that a single fill pattern would hide.

// File: rtl/cmdspi_pkg.sv
package cmdspi_pkg;

  localparam int unsigned IRQ_N = 4;
  localparam int unsigned IRQ_CMD_LOW  = 0;
  localparam int unsigned IRQ_OUT_LOW  = 1;
  localparam int unsigned IRQ_IN_HIGH  = 2;
  localparam int unsigned IRQ_SYNC     = 3;

  localparam int unsigned OFF_VERSION  = 'h00;
  localparam int unsigned OFF_SOFTRST  = 'h40;
  localparam int unsigned OFF_IRQ_EN   = 'h80;
  localparam int unsigned OFF_IRQ_PEND = 'h84;
  localparam int unsigned OFF_IRQ_SRC  = 'h88;
  localparam int unsigned OFF_SYNC_ID  = 'hC0;
  localparam int unsigned OFF_CMD_ROOM = 'hD0;
  localparam int unsigned OFF_OUT_ROOM = 'hD4;
  localparam int unsigned OFF_IN_LVL   = 'hD8;
  localparam int unsigned OFF_CMD_PUSH = 'hE0;
  localparam int unsigned OFF_OUT_PUSH = 'hE4;
  localparam int unsigned OFF_IN_POP   = 'hE8;
  localparam int unsigned OFF_IN_PEEK  = 'hEC;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic        pushCmd;
    logic        pushOut;
    logic        popIn;
    logic        flush;
    logic [15:0] wrWord;
  } hostStrb_t;

endpackage

// File: rtl/cmdspi_fifo.sv
module cmdspi_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic doPush, doPop;

  assign full     = (count == LVL_W'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = push && !full && !flush;
  assign doPop    = pop && !empty && !flush;
  assign headData = mem[rdPtr];
  assign level    = count;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cmdspi_dpath.sv
module cmdspi_dpath
  import cmdspi_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  localparam int CMD_LVL_W = $clog2(CMD_DEPTH) + 1,
  localparam int OUT_LVL_W = $clog2(OUT_DEPTH) + 1,
  localparam int IN_LVL_W  = $clog2(IN_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hostStrb_t            strb,
  output logic                 cmdValid,
  input  logic                 cmdReady,
  output logic [15:0]          cmdData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [7:0]           outData,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [7:0]           inData,
  output logic [CMD_LVL_W-1:0] cmdLevel,
  output logic [OUT_LVL_W-1:0] outLevel,
  output logic [IN_LVL_W-1:0]  inLevel,
  output logic [7:0]           inHead,
  output logic                 inEmpty
);

  logic cmdFull, cmdEmpty, outFull, outEmpty, inFull;

  assign cmdValid = !cmdEmpty && !strb.flush;
  assign outValid = !outEmpty && !strb.flush;
  assign inReady  = !inFull && !strb.flush;

  cmdspi_fifo #(.WIDTH(16), .DEPTH(CMD_DEPTH)) u_cmdFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.pushCmd), .pushData(strb.wrWord),
    .pop(cmdValid && cmdReady), .headData(cmdData),
    .level(cmdLevel), .full(cmdFull), .empty(cmdEmpty)
  );

  cmdspi_fifo #(.WIDTH(8), .DEPTH(OUT_DEPTH)) u_outFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.pushOut), .pushData(strb.wrWord[7:0]),
    .pop(outValid && outReady), .headData(outData),
    .level(outLevel), .full(outFull), .empty(outEmpty)
  );

  cmdspi_fifo #(.WIDTH(8), .DEPTH(IN_DEPTH)) u_inFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(inValid && inReady), .pushData(inData),
    .pop(strb.popIn), .headData(inHead),
    .level(inLevel), .full(inFull), .empty(inEmpty)
  );

endmodule

// File: rtl/cmdspi_ctrl.sv
module cmdspi_ctrl
  import cmdspi_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int CMD_DEPTH    = 16,
  parameter int OUT_DEPTH    = 16,
  parameter int IN_DEPTH     = 16,
  parameter int CMD_LOW_MARK = 4,
  parameter int OUT_LOW_MARK = 4,
  parameter int IN_HIGH_MARK = 12,
  parameter int VER_MAJOR    = 1,
  parameter int VER_MINOR    = 0,
  parameter int VER_PATCH    = 'h61,
  localparam int CMD_LVL_W = $clog2(CMD_DEPTH) + 1,
  localparam int OUT_LVL_W = $clog2(OUT_DEPTH) + 1,
  localparam int IN_LVL_W  = $clog2(IN_DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic                 irq,
  output logic                 engineRst,
  input  logic                 syncValid,
  input  logic [7:0]           syncId,
  input  logic [CMD_LVL_W-1:0] cmdLevel,
  input  logic [OUT_LVL_W-1:0] outLevel,
  input  logic [IN_LVL_W-1:0]  inLevel,
  input  logic [7:0]           inHead,
  input  logic                 inEmpty,
  output hostStrb_t            strb
);

  localparam logic [31:0] VERSION_WORD =
    {8'h00, 8'(VER_MAJOR), 8'(VER_MINOR), 8'(VER_PATCH)};

  logic             softRstQ;
  logic [IRQ_N-1:0] enQ, pendQ, setBits, clrBits, srcBits;
  logic [7:0]       syncIdQ;
  logic [31:0]      rdMux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  // Strobes to the datapath
  always_comb begin
    strb.flush   = softRstQ;
    strb.wrWord  = wrData[15:0];
    strb.pushCmd = wrEn && hit(addr, OFF_CMD_PUSH) && !softRstQ;
    strb.pushOut = wrEn && hit(addr, OFF_OUT_PUSH) && !softRstQ;
    strb.popIn   = rdEn && hit(addr, OFF_IN_POP) && !softRstQ;
  end

  // Interrupt set and clear terms
  always_comb begin
    setBits = '0;
    setBits[IRQ_CMD_LOW] = (32'(cmdLevel) <= 32'(CMD_LOW_MARK));
    setBits[IRQ_OUT_LOW] = (32'(outLevel) <= 32'(OUT_LOW_MARK));
    setBits[IRQ_IN_HIGH] = (32'(inLevel)  >= 32'(IN_HIGH_MARK));
    setBits[IRQ_SYNC]    = syncValid;
    clrBits = (wrEn && hit(addr, OFF_IRQ_PEND)) ? wrData[IRQ_N-1:0] : '0;
  end

  assign srcBits   = pendQ & enQ;
  assign irq       = |srcBits;
  assign engineRst = softRstQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRstQ <= 1'b1;
      enQ      <= '0;
      pendQ    <= '0;
      syncIdQ  <= '0;
    end else begin
      if (wrEn && hit(addr, OFF_SOFTRST)) softRstQ <= wrData[0];
      if (wrEn && hit(addr, OFF_IRQ_EN))  enQ <= wrData[IRQ_N-1:0];
      pendQ <= (pendQ & ~clrBits) | setBits;
      if (syncValid) syncIdQ <= syncId;
    end
  end

  // Read multiplexer
  always_comb begin
    rdMux = '0;
    if      (hit(addr, OFF_VERSION))  rdMux = VERSION_WORD;
    else if (hit(addr, OFF_SOFTRST))  rdMux = {31'd0, softRstQ};
    else if (hit(addr, OFF_IRQ_EN))   rdMux = 32'(enQ);
    else if (hit(addr, OFF_IRQ_PEND)) rdMux = 32'(pendQ);
    else if (hit(addr, OFF_IRQ_SRC))  rdMux = 32'(srcBits);
    else if (hit(addr, OFF_SYNC_ID))  rdMux = 32'(syncIdQ);
    else if (hit(addr, OFF_CMD_ROOM)) rdMux = 32'(CMD_DEPTH) - 32'(cmdLevel);
    else if (hit(addr, OFF_OUT_ROOM)) rdMux = 32'(OUT_DEPTH) - 32'(outLevel);
    else if (hit(addr, OFF_IN_LVL))   rdMux = 32'(inLevel);
    else if (hit(addr, OFF_IN_POP) || hit(addr, OFF_IN_PEEK))
      rdMux = inEmpty ? 32'd0 : 32'(inHead);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/cmdspi_host_regs.sv
module cmdspi_host_regs
  import cmdspi_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int CMD_DEPTH    = 16,
  parameter int OUT_DEPTH    = 16,
  parameter int IN_DEPTH     = 16,
  parameter int CMD_LOW_MARK = 4,
  parameter int OUT_LOW_MARK = 4,
  parameter int IN_HIGH_MARK = 12,
  parameter int VER_MAJOR    = 1,
  parameter int VER_MINOR    = 0,
  parameter int VER_PATCH    = 'h61
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              irq,
  output logic              engineRst,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [15:0]       cmdData,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              syncValid,
  input  logic [7:0]        syncId
);

  localparam int CMD_LVL_W = $clog2(CMD_DEPTH) + 1;
  localparam int OUT_LVL_W = $clog2(OUT_DEPTH) + 1;
  localparam int IN_LVL_W  = $clog2(IN_DEPTH) + 1;

  hostStrb_t            strb;
  logic [CMD_LVL_W-1:0] cmdLevel;
  logic [OUT_LVL_W-1:0] outLevel;
  logic [IN_LVL_W-1:0]  inLevel;
  logic [7:0]           inHead;
  logic                 inEmpty;

  cmdspi_ctrl #(
    .ADDR_W(ADDR_W), .CMD_DEPTH(CMD_DEPTH), .OUT_DEPTH(OUT_DEPTH),
    .IN_DEPTH(IN_DEPTH), .CMD_LOW_MARK(CMD_LOW_MARK),
    .OUT_LOW_MARK(OUT_LOW_MARK), .IN_HIGH_MARK(IN_HIGH_MARK),
    .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .irq(irq),
    .engineRst(engineRst), .syncValid(syncValid), .syncId(syncId),
    .cmdLevel(cmdLevel), .outLevel(outLevel), .inLevel(inLevel),
    .inHead(inHead), .inEmpty(inEmpty), .strb(strb)
  );

  cmdspi_dpath #(
    .CMD_DEPTH(CMD_DEPTH), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .cmdLevel(cmdLevel), .outLevel(outLevel), .inLevel(inLevel),
    .inHead(inHead), .inEmpty(inEmpty)
  );

endmodule

// File: rtl/cmdspi_chk.sv
module cmdspi_chk
  import cmdspi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CMD_DEPTH = 16,
  parameter int IN_DEPTH  = 16,
  localparam int CMD_LVL_W = $clog2(CMD_DEPTH) + 1,
  localparam int IN_LVL_W  = $clog2(IN_DEPTH) + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic                 engineRst,
  input logic                 cmdValid,
  input logic                 cmdReady,
  input logic                 outValid,
  input logic                 inValid,
  input logic                 inReady,
  input hostStrb_t            strb,
  input logic [CMD_LVL_W-1:0] cmdLevel,
  input logic [IN_LVL_W-1:0]  inLevel
);

  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    engineRst |-> (!cmdValid && !outValid && !inReady));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    32'(cmdLevel) <= 32'(CMD_DEPTH));

  a_r6_ready_below_full: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (32'(inLevel) < 32'(IN_DEPTH)));

  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pushCmd && !(cmdValid && cmdReady) && (32'(cmdLevel) < 32'(CMD_DEPTH)))
    |=> (cmdLevel == $past(cmdLevel) + 1'b1));

  a_r7_peek_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OFF_IN_PEEK) && !(inValid && inReady))
    |=> (inLevel == $past(inLevel)));

endmodule

bind cmdspi_host_regs cmdspi_chk #(
  .ADDR_W(ADDR_W), .CMD_DEPTH(CMD_DEPTH), .IN_DEPTH(IN_DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .engineRst(engineRst),
  .cmdValid(cmdValid), .cmdReady(cmdReady), .outValid(outValid),
  .inValid(inValid), .inReady(inReady), .strb(strb),
  .cmdLevel(cmdLevel), .inLevel(inLevel)
);

// File: tb/tb_cmdspi_host_regs.sv
module tb_cmdspi_host_regs;

  localparam int CLK_PERIOD = 10;
  localparam int CMD_DEPTH = 16;
  localparam int OUT_DEPTH = 16;
  localparam int IN_DEPTH  = 16;
  localparam int CMD_LOW   = 4;
  localparam int OUT_LOW   = 4;
  localparam int IN_HIGH   = 12;

  logic clk, rstN, wrEn, rdEn, rdValid, irq, engineRst;
  logic [7:0] addr;
  logic [31:0] wrData, rdData;
  logic cmdValid, cmdReady, outValid, outReady, inValid, inReady, syncValid;
  logic [15:0] cmdData;
  logic [7:0] outData, inData, syncId;

  cmdspi_host_regs #(
    .CMD_DEPTH(CMD_DEPTH), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH),
    .CMD_LOW_MARK(CMD_LOW), .OUT_LOW_MARK(OUT_LOW), .IN_HIGH_MARK(IN_HIGH)
  ) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .irq(irq),
    .engineRst(engineRst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdData(cmdData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .inValid(inValid), .inReady(inReady),
    .inData(inData), .syncValid(syncValid), .syncId(syncId)
  );

  int checks = 0;
  int errors = 0;
  bit held = 1'b1;
  logic [15:0] cmdQ[$];
  logic [7:0]  outQ[$];
  logic [7:0]  inQ[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expCond();
    logic [31:0] v = '0;
    v[0] = (cmdQ.size() <= CMD_LOW);
    v[1] = (outQ.size() <= OUT_LOW);
    v[2] = (inQ.size() >= IN_HIGH);
    return v;
  endfunction

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic hostPushCmd(input logic [15:0] v);
    busWr(8'hE0, {16'hDEAD, v});
    if (!held && cmdQ.size() < CMD_DEPTH) cmdQ.push_back(v);
  endtask

  task automatic hostPushOut(input logic [7:0] v);
    busWr(8'hE4, {24'hABCDEF, v});
    if (!held && outQ.size() < OUT_DEPTH) outQ.push_back(v);
  endtask

  task automatic engPushIn(input logic [7:0] v);
    @(negedge clk); inValid = 1'b1; inData = v;
    @(negedge clk); inValid = 1'b0;
    if (!held && inQ.size() < IN_DEPTH) inQ.push_back(v);
  endtask

  task automatic hostPopIn();
    logic [31:0] d, e;
    busRd(8'hE8, d);
    e = (inQ.size() != 0) ? 32'(inQ.pop_front()) : 32'd0;
    check("R6/R8 pop byte", d, e);
  endtask

  task automatic hostPeek();
    logic [31:0] d;
    busRd(8'hEC, d);
    check("R7 peek byte", d, (inQ.size() != 0) ? 32'(inQ[0]) : 32'd0);
  endtask

  task automatic engPullCmd();
    @(negedge clk);
    if (cmdQ.size() != 0) begin
      check("R4 cmd valid", 32'(cmdValid), 32'd1);
      check("R4 cmd order", 32'(cmdData), 32'(cmdQ[0]));
      cmdReady = 1'b1;
      @(negedge clk); cmdReady = 1'b0;
      void'(cmdQ.pop_front());
    end else check("R4 cmd idle", 32'(cmdValid), 32'd0);
  endtask

  task automatic engPullOut();
    @(negedge clk);
    if (outQ.size() != 0) begin
      check("R5 out valid", 32'(outValid), 32'd1);
      check("R5 out order", 32'(outData), 32'(outQ[0]));
      outReady = 1'b1;
      @(negedge clk); outReady = 1'b0;
      void'(outQ.pop_front());
    end else check("R5 out idle", 32'(outValid), 32'd0);
  endtask

  task automatic checkLevels(input string tag);
    logic [31:0] d;
    busRd(8'hD0, d); check({"R3 cmd room ", tag}, d, 32'(CMD_DEPTH - cmdQ.size()));
    busRd(8'hD4, d); check({"R3 out room ", tag}, d, 32'(OUT_DEPTH - outQ.size()));
    busRd(8'hD8, d); check({"R3 in level ", tag}, d, 32'(inQ.size()));
  endtask

  task automatic checkPendFresh(input string tag);
    logic [31:0] d;
    busWr(8'h84, 32'hFF);
    busRd(8'h84, d);
    check({"R9/R10 pending ", tag}, d, expCond());
  endtask

  task automatic pulseSync(input logic [7:0] id);
    @(negedge clk); syncValid = 1'b1; syncId = id;
    @(negedge clk); syncValid = 1'b0;
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; wrEn = 0; rdEn = 0; addr = 0; wrData = 0;
    cmdReady = 0; outReady = 0; inValid = 0; inData = 0;
    syncValid = 0; syncId = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    busRd(8'h00, d); check("R1 version", d, 32'h0001_0061);
    busRd(8'h40, d); check("R2 soft reset after rstN", d, 32'd1);
    check("R2 engineRst held", 32'(engineRst), 32'd1);
    check("R2 inReady low while held", 32'(inReady), 32'd0);
    busRd(8'h80, d); check("R13 enable after reset", d, 32'd0);
    busRd(8'hC0, d); check("R11 sync id after reset", d, 32'd0);
    busRd(8'h84, d); check("R9 pending after reset", d, 32'h3);
    check("R12 irq idle", 32'(irq), 32'd0);

    // Pushes ignored while held
    hostPushCmd(16'h1111); hostPushOut(8'h22); engPushIn(8'h33);
    checkLevels("held");
    busWr(8'h40, 32'h0); held = 1'b0;
    check("R2 released", 32'(engineRst), 32'd0);

    // Enable register
    busWr(8'h80, 32'hFFFF_FFFF);
    busRd(8'h80, d); check("R13 enable width", d, 32'hF);
    busWr(8'h80, 32'h0);

    // Command FIFO fill past full
    for (int i = 0; i < CMD_DEPTH + 2; i++) hostPushCmd(16'hC000 + 16'(i * 7));
    checkLevels("cmd full");
    checkPendFresh("cmd full");
    for (int i = 0; i < CMD_DEPTH; i++) engPullCmd();
    engPullCmd();

    // Transmit FIFO
    for (int i = 0; i < 3; i++) hostPushOut(8'h50 + 8'(i));
    checkLevels("out three");
    for (int i = 0; i < 4; i++) engPullOut();

    // Receive FIFO, peek and empty pop
    engPushIn(8'hA1); engPushIn(8'hB2);
    hostPeek(); hostPeek();
    checkLevels("after peek");
    hostPopIn(); hostPopIn(); hostPopIn();
    checkLevels("in empty");

    // Receive FIFO past the high mark and past full
    for (int i = 0; i < IN_HIGH; i++) engPushIn(8'(i + 1));
    checkPendFresh("in high");
    for (int i = 0; i < IN_DEPTH; i++) engPushIn(8'(8'h80 + i));
    check("R6 inReady low when full", 32'(inReady), 32'd0);
    checkLevels("in full");
    while (inQ.size() != 0) hostPopIn();

    // Write-one-to-clear and re-assertion
    busWr(8'h84, 32'h1);
    busRd(8'h84, d); check("R10 held watermark re-sets", d & 32'h1, 32'h1);
    pulseSync(8'hA5);
    busRd(8'hC0, d); check("R11 sync id captured", d, 32'hA5);
    busRd(8'h84, d); check("R11 sync pending", d & 32'h8, 32'h8);
    busWr(8'h84, 32'h2);
    busRd(8'h84, d); check("R10 zero bits keep sync", d & 32'h8, 32'h8);
    busWr(8'h84, 32'h8);
    busRd(8'h84, d); check("R10 sync cleared", d & 32'h8, 32'h0);

    // Source register and interrupt line
    busWr(8'h80, 32'h8);
    check("R12 irq masked watermarks", 32'(irq), 32'd0);
    pulseSync(8'h3C);
    check("R12 irq on sync", 32'(irq), 32'd1);
    busRd(8'h88, d); check("R12 source", d, 32'h8);
    busWr(8'h80, 32'h2);
    busRd(8'h88, d); check("R12 source mask", d, 32'h2);
    busWr(8'h84, 32'hFF); busWr(8'h80, 32'h4);
    check("R12 irq low", 32'(irq), 32'd0);
    busWr(8'h80, 32'h0);

    // Soft reset flushes contents
    hostPushCmd(16'h0101); hostPushCmd(16'h0202); hostPushOut(8'h77);
    engPushIn(8'h66); engPushIn(8'h55);
    busWr(8'h40, 32'h1); held = 1'b1;
    cmdQ.delete(); outQ.delete(); inQ.delete();
    check("R2 cmdValid held", 32'(cmdValid), 32'd0);
    checkLevels("flushed");
    busRd(8'hC0, d); check("R2 sync id kept", d, 32'h3C);
    busWr(8'h40, 32'h0); held = 1'b0;

    // Seeded random mix
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 9);
      case (op)
        0: hostPushCmd(16'($urandom));
        1: hostPushOut(8'($urandom));
        2: engPushIn(8'($urandom));
        3: hostPopIn();
        4: hostPeek();
        5: engPullCmd();
        6: engPullOut();
        7: checkLevels("random");
        default: checkPendFresh("random");
      endcase
    end
    checkLevels("end");
    finish();
  end

endmodule